// File: doc/BRIEF.md
# Jump Target Address Generator

This block forms the next program counter for the unconditional jump instructions of an 8-bit microcontroller core. Each cycle it takes the current opcode and the two bytes after it. It also takes the address of the instruction that follows, which the fetch logic has already advanced by the length of the instruction: 1 byte for the indirect form, 2 bytes for the absolute and short forms, 3 bytes for the long form. The accumulator and the 16-bit data pointer are inputs as well.

The block decodes four jump forms. The indirect form adds the accumulator to the data pointer. The absolute form stays inside the current 2 KB page: it keeps the upper five bits of the following address and takes the rest from three opcode bits and an operand byte. The long form loads a full 16-bit address from the operand bytes. The short form adds a signed byte to the following address. The result is registered together with a taken flag. For every other opcode, including the absolute-call encodings, the block passes the following address through with the flag clear. The accumulator and the data pointer are only read and are never altered.

Top module: `jmpTargetGen`

## Requirements
- R1: While rstN is low, pcOut is 0000h and taken is 0.
- R2: Outputs are registered. pcOut and taken after a rising clock edge reflect only the inputs sampled at that edge.
- R3: For opcode 73h, taken is 1 and pcOut is dataPtr plus the zero-extended accum, modulo 2^16.
- R4: An opcode with bits [3:0] = 0001 and bit 4 = 0 is an absolute jump. taken is 1 and pcOut is {nextPc[15:11], opcode[7:5], operandB}.
- R5: An opcode with bits [3:0] = 0001 and bit 4 = 1 is an absolute call. It is not a jump here, so taken is 0 and pcOut equals nextPc.
- R6: For opcode 02h, taken is 1. pcOut[15:8] is operandB and pcOut[7:0] is operandC.
- R7: For opcode 80h, taken is 1 and pcOut is nextPc plus operandB sign-extended to 16 bits, modulo 2^16, so the reach is -128 to +127 bytes.
- R8: Every other opcode gives taken 0 and pcOut equal to nextPc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | 8 | First instruction byte |
| operandB | input | 8 | Second instruction byte |
| operandC | input | 8 | Third instruction byte |
| nextPc | input | 16 | Address of the following instruction |
| accum | input | 8 | Accumulator value |
| dataPtr | input | 16 | Data pointer value |
| pcOut | output | 16 | Registered next program counter |
| taken | output | 1 | Registered jump-taken flag |

## Verification
The bench sweeps all 256 opcodes against several operand sets. Each set places nextPc at a page edge or at the ends of the address space, and uses operand bytes of 00h, 7Fh, 80h and FFh. The 80h and 7Fh bytes show whether the short offset is sign-extended. Values of nextPc near page boundaries show whether the absolute form keeps only the upper five bits and whether it is told apart from the call encodings that differ in bit 4. Directed cases make the short and indirect sums wrap past FFFFh and 0000h, and a back-to-back sequence shows that each result depends only on the inputs of its own edge.

// File: rtl/jtgPkg.sv
package jtgPkg;
  typedef struct packed {
    logic selIndirect;
    logic selAbsolute;
    logic selLong;
    logic selShort;
  } jmpStb_t;

  localparam logic [7:0] OPC_INDIRECT = 8'h73;
  localparam logic [7:0] OPC_LONG     = 8'h02;
  localparam logic [7:0] OPC_SHORT    = 8'h80;
endpackage

// File: rtl/jtgDecode.sv
module jtgDecode
  import jtgPkg::*;
(
  input  logic [7:0] opcode,
  output jmpStb_t    stb
);
  logic lowIsOne;
  assign lowIsOne = (opcode[3:0] == 4'h1);

  always_comb begin
    stb = '0;
    stb.selIndirect = (opcode == OPC_INDIRECT);
    stb.selLong     = (opcode == OPC_LONG);
    stb.selShort    = (opcode == OPC_SHORT);
    // even high nibble -> jump; odd high nibble -> call (not handled here)
    stb.selAbsolute = lowIsOne && !opcode[4];
  end
endmodule

// File: rtl/jtgAddrPath.sv
module jtgAddrPath
  import jtgPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  jmpStb_t             stb,
  input  logic [DATA_W-1:0]   opcode,
  input  logic [DATA_W-1:0]   operandB,
  input  logic [DATA_W-1:0]   operandC,
  input  logic [2*DATA_W-1:0] nextPc,
  input  logic [DATA_W-1:0]   accum,
  input  logic [2*DATA_W-1:0] dataPtr,
  output logic [2*DATA_W-1:0] pcOut,
  output logic                taken
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int PAGE_W = DATA_W + 3;

  logic [ADDR_W-1:0] indirectTgt, absoluteTgt, longTgt, shortTgt, nextTgt;
  logic              anyTaken;

  assign indirectTgt = dataPtr + {{(ADDR_W-DATA_W){1'b0}}, accum};
  assign absoluteTgt = {nextPc[ADDR_W-1:PAGE_W], opcode[DATA_W-1 -: 3], operandB};
  assign longTgt     = {operandB, operandC};
  assign shortTgt    = nextPc + {{(ADDR_W-DATA_W){operandB[DATA_W-1]}}, operandB};

  always_comb begin
    nextTgt = nextPc;
    unique case (1'b1)
      stb.selIndirect: nextTgt = indirectTgt;
      stb.selAbsolute: nextTgt = absoluteTgt;
      stb.selLong:     nextTgt = longTgt;
      stb.selShort:    nextTgt = shortTgt;
      default:         nextTgt = nextPc;
    endcase
  end

  assign anyTaken = |stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcOut <= '0;
      taken <= 1'b0;
    end else begin
      pcOut <= nextTgt;
      taken <= anyTaken;
    end
  end
endmodule

// File: rtl/jmpTargetGen.sv
module jmpTargetGen
  import jtgPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   opcode,
  input  logic [DATA_W-1:0]   operandB,
  input  logic [DATA_W-1:0]   operandC,
  input  logic [2*DATA_W-1:0] nextPc,
  input  logic [DATA_W-1:0]   accum,
  input  logic [2*DATA_W-1:0] dataPtr,
  output logic [2*DATA_W-1:0] pcOut,
  output logic                taken
);
  jmpStb_t stb;

  jtgDecode u_decode (
    .opcode (opcode),
    .stb    (stb)
  );

  jtgAddrPath #(.DATA_W(DATA_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .opcode   (opcode),
    .operandB (operandB),
    .operandC (operandC),
    .nextPc   (nextPc),
    .accum    (accum),
    .dataPtr  (dataPtr),
    .pcOut    (pcOut),
    .taken    (taken)
  );
endmodule

// File: rtl/jmpTargetGenChk.sv
module jmpTargetGenChk
  import jtgPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  opcode,
  input logic [7:0]  operandB,
  input logic [7:0]  operandC,
  input logic [15:0] nextPc,
  input logic [7:0]  accum,
  input logic [15:0] dataPtr,
  input logic [15:0] pcOut,
  input logic        taken,
  input jmpStb_t     stb
);
  logic live;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) !rstN |-> (pcOut == 16'h0 && !taken));

  // R3
  a_r3_indirect: assert property (@(posedge clk) disable iff (!rstN)
    (live && opcode == 8'h73) |=> (taken && pcOut == $past(dataPtr) + {8'h00, $past(accum)}));

  // R4
  a_r4_absolute: assert property (@(posedge clk) disable iff (!rstN)
    (live && opcode[3:0] == 4'h1 && !opcode[4]) |=>
      (taken && pcOut[15:11] == $past(nextPc[15:11]) && pcOut[10:8] == $past(opcode[7:5])
       && pcOut[7:0] == $past(operandB)));

  // R5
  a_r5_call_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (live && opcode[3:0] == 4'h1 && opcode[4]) |=> (!taken && pcOut == $past(nextPc)));

  // R6
  a_r6_long: assert property (@(posedge clk) disable iff (!rstN)
    (live && opcode == 8'h02) |=> (taken && pcOut == {$past(operandB), $past(operandC)}));

  // R7
  a_r7_short: assert property (@(posedge clk) disable iff (!rstN)
    (live && opcode == 8'h80) |=>
      (taken && pcOut == $past(nextPc) + {{8{$past(operandB[7])}}, $past(operandB)}));

  // R8
  a_r8_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    (live && stb == '0) |=> (!taken && pcOut == $past(nextPc)));

  // R2: decode selects at most one form
  a_r2_one_form: assert property (@(posedge clk) disable iff (!rstN) $onehot0(stb));
endmodule

bind jmpTargetGen jmpTargetGenChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opcode   (opcode),
  .operandB (operandB),
  .operandC (operandC),
  .nextPc   (nextPc),
  .accum    (accum),
  .dataPtr  (dataPtr),
  .pcOut    (pcOut),
  .taken    (taken),
  .stb      (stb)
);

// File: tb/test_jmpTargetGen.sv
`timescale 1ns/1ps
module test_jmpTargetGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  opcode = '0, operandB = '0, operandC = '0, accum = '0;
  logic [15:0] nextPc = '0, dataPtr = '0;
  logic [15:0] pcOut;
  logic        taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  jmpTargetGen i_jmpTargetGen (
    .clk(clk), .rstN(rstN), .opcode(opcode), .operandB(operandB), .operandC(operandC),
    .nextPc(nextPc), .accum(accum), .dataPtr(dataPtr), .pcOut(pcOut), .taken(taken)
  );

  function automatic string tagOf(input logic [7:0] op);
    if (op == 8'h73) return "R3";
    if (op == 8'h02) return "R6";
    if (op == 8'h80) return "R7";
    if (op % 16 == 1) return ((op / 16) % 2 == 0) ? "R4" : "R5";
    return "R8";
  endfunction

  task automatic expectFor(input logic [7:0] op, input logic [7:0] b, input logic [7:0] c,
                           input logic [15:0] np, input logic [7:0] a, input logic [15:0] dp,
                           output logic [15:0] ePc, output logic eTk);
    int sum;
    int off;
    eTk = 1'b1;
    if (op == 8'h73) begin
      sum = (int'(dp) + int'(a)) % 65536;
      ePc = 16'(sum);
    end else if (op == 8'h02) begin
      ePc = 16'(int'(b) * 256 + int'(c));
    end else if (op == 8'h80) begin
      off = (b >= 8'd128) ? int'(b) - 256 : int'(b);
      sum = (int'(np) + off + 65536) % 65536;
      ePc = 16'(sum);
    end else if (op % 16 == 1 && (op / 16) % 2 == 0) begin
      sum = (int'(np) / 2048) * 2048 + (int'(op) / 32) * 256 + int'(b);
      ePc = 16'(sum);
    end else begin
      eTk = 1'b0;
      ePc = np;
    end
  endtask

  task automatic check(input string tag, input logic [15:0] ePc, input logic eTk);
    checks++;
    if (pcOut !== ePc || taken !== eTk) begin
      fails++;
      $display("FAIL %s: pcOut=%h taken=%b, expected pcOut=%h taken=%b", tag, pcOut, taken, ePc, eTk);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] b, input logic [7:0] c,
                     input logic [15:0] np, input logic [7:0] a, input logic [15:0] dp);
    logic [15:0] ePc;
    logic eTk;
    expectFor(op, b, c, np, a, dp, ePc, eTk);
    opcode = op; operandB = b; operandC = c; nextPc = np; accum = a; dataPtr = dp;
    @(posedge clk); #2;
    check(tagOf(op), ePc, eTk);
  endtask

  initial begin
    logic [15:0] npSet [6] = '{16'h0000, 16'h07FF, 16'h0800, 16'hF8FE, 16'hFFFF, 16'h1234};
    logic [7:0]  bSet  [6] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h5A, 8'hC3};
    #2;
    @(posedge clk); #2;
    check("R1", 16'h0000, 1'b0);
    rstN = 1'b1;
    opcode = 8'h02; operandB = 8'hAB; operandC = 8'hCD;
    #1;
    check("R1", 16'h0000, 1'b0);   // R2: no change before an edge

    for (int p = 0; p < 6; p++) begin
      for (int op = 0; op < 256; op++) begin
        run(8'(op), bSet[p], 8'(8'hA5 ^ bSet[p]), npSet[p], 8'(bSet[(p+1)%6]), 16'(npSet[(p+2)%6] ^ 16'h0F0F));
      end
    end

    // R7: wrap both ways and extreme offsets
    run(8'h80, 8'h01, 8'h00, 16'hFFFF, 8'h00, 16'h0000);
    check("R7", 16'h0000, 1'b1);
    run(8'h80, 8'h80, 8'h00, 16'h0000, 8'h00, 16'h0000);
    check("R7", 16'hFF80, 1'b1);
    run(8'h80, 8'h7F, 8'h00, 16'h1000, 8'h00, 16'h0000);
    check("R7", 16'h107F, 1'b1);
    // R3: wrap of indirect sum
    run(8'h73, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'hFFFF);
    check("R3", 16'h00FE, 1'b1);
    // R4: top page, top opcode bits
    run(8'hE1, 8'h34, 8'h00, 16'hFFFF, 8'h00, 16'h0000);
    check("R4", 16'hFF34, 1'b1);
    // R5: call encoding is passed through
    run(8'hF1, 8'h34, 8'h00, 16'h4321, 8'h00, 16'h0000);
    check("R5", 16'h4321, 1'b0);
    // R2: back-to-back results follow their own edge
    run(8'h02, 8'h12, 8'h34, 16'hAAAA, 8'h00, 16'h0000);
    run(8'h00, 8'h12, 8'h34, 16'hAAAA, 8'h00, 16'h0000);
    check("R2", 16'hAAAA, 1'b0);

    // R1: asynchronous reset clears outputs
    run(8'h02, 8'hBE, 8'hEF, 16'h0000, 8'h00, 16'h0000);
    rstN = 1'b0; #1;
    check("R1", 16'h0000, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule